// File: doc/BRIEF.md
# Tagged FIFO Communication Cell

This block is one storage cell that lets threads pass data words to each other. The cell holds a small circular buffer and a tag. The tag has an empty flag, a full flag, a trap bit, a constant FIFO-type flag, a fill count and a depth code. Each request carries a view code. The view code chooses how the same buffer is reached:

- **Bypass view:** direct data access with no side effects.
- **Control view:** raw access to the tag.
- **Blocking empty/full view:** pop on read, push on write, and stall when the cell cannot serve the access.
- **Non-blocking empty/full view:** pop on read and push on write, but never stall.

A blocking access that cannot proceed gets a stall response, and the requester's identifier is recorded in a blocked-requester mask. The next empty/full access that does not stall raises a one-cycle wake pulse carrying that mask, then clears the mask. The scheduler uses the pulse to retry the sleeping requesters. Address decoding and thread scheduling are outside the block.

Every request is accepted in one cycle. Its response (valid, stall, read data) is registered and appears on the following cycle, together with any wake pulse that the request caused. The block has no multi-state sequencer. Its flow is one operation decoder, `unique case` on the view code, that feeds one state register process and one output register process.

Top module: `tfc_cell`

## Requirements
- R1: After reset the tag is: empty flag set, full flag clear, trap bit clear, fill count 0, FIFO-type flag set, depth code equal to log2(DEPTH). No wake pulse is pending and the blocked mask is clear. For DEPTH=8 a control read returns 0x3002_0001.
- R2: View codes are 0 = bypass, 1 = control, 2 = blocking empty/full, 3 = non-blocking empty/full. A control-view read returns this word, with all other bits zero:
  - depth code at bits 31:28
  - fill count at bits 18 and up (log2(DEPTH)+1 bits)
  - FIFO-type flag at bit 17
  - trap bit at bit 16
  - full flag at bit 1
  - empty flag at bit 0
- R3: A control-view write loads the trap, full and empty flags from write-data bits 16, 1 and 0 and leaves the other tag fields alone. When bit 0 is written as 1, the fill count is cleared.
- R4: An empty/full read clears the full flag. If it does not stall and the count is nonzero, it returns the oldest entry, advances the head modulo DEPTH and decrements the count. The empty flag is set whenever the count is then zero. A read with count zero returns 0.
- R5: A blocking empty/full read while the empty flag is set returns a stall response and returns no data. It pops nothing and adds the requester's bit to the blocked mask.
- R6: An empty/full write clears the empty flag. If it does not stall and the count is below DEPTH, it appends the data. The full flag is set whenever the count then equals DEPTH. A non-blocking write to a cell holding DEPTH entries drops its data.
- R7: A blocking empty/full write while the full flag is set, including a full flag set by software, returns a stall response, stores nothing and adds the requester's bit to the blocked mask.
- R8: An empty/full access that does not stall, made while the blocked mask is nonzero, produces on the response cycle a wake pulse lasting exactly one cycle. The pulse carries the mask, and the mask is cleared. A stalled access never wakes.
- R9: A bypass read returns the head entry without popping. A bypass write replaces the newest entry only when the count is nonzero; with count zero it is ignored. Bypass writes never change the tag.
- R10: The response is valid exactly one cycle after each request. Writes return 0. View codes 4 to 7 change nothing and return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | 3 | Access view code |
| req_id | input | IDW (3) | Requester identifier |
| req_wdata | input | DW (64) | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_stall | output | 1 | Blocking access could not complete |
| rsp_rdata | output | DW (64) | Read data |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_mask | output | NREQ (8) | Requesters to wake, valid with the pulse |

## Verification
The bench walks the buffer around its wrap point and fills it to exactly DEPTH entries. A wrong full comparison or head increment would either accept a ninth push or misorder the popped words. It stalls two requesters on a full cell and checks that a dropped non-blocking write still wakes both with the combined mask. A design that woke only on a successful push would miss that wake. It sets the full flag through the control view on an empty cell to show that a blocking write stalls on the flag and not on the count. It also checks that a bypass write to an empty cell and accesses with unused view codes leave the tag word unchanged. Finally it checks that a wake pulse never repeats and that reset discards pending blocked requesters.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

    typedef enum logic [2:0] {
        VW_BYPASS  = 3'd0,
        VW_CTRL    = 3'd1,
        VW_EF_SYNC = 3'd2,
        VW_EF_TRY  = 3'd3
    } view_e;

    // Bit positions of the tag word seen through the control view
    localparam int TB_DCODE = 28;
    localparam int TB_PTR   = 18;
    localparam int TB_FIFO  = 17;
    localparam int TB_TRAP  = 16;
    localparam int TB_FULL  = 1;
    localparam int TB_EMPTY = 0;

endpackage

// File: rtl/tfc_store.sv
module tfc_store #(
    parameter int DW    = 64,
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/tfc_waker.sv
module tfc_waker #(
    parameter int NREQ = 8,
    localparam int IDW = $clog2(NREQ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            add_en,
    input  logic [IDW-1:0]  add_id,
    input  logic            fire,
    output logic            wake_pulse,
    output logic [NREQ-1:0] wake_mask
);

    logic [NREQ-1:0] blocked_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked_q  <= '0;
            wake_pulse <= 1'b0;
            wake_mask  <= '0;
        end else begin
            wake_pulse <= 1'b0;
            wake_mask  <= '0;
            if (fire && (blocked_q != '0)) begin
                wake_pulse <= 1'b1;
                wake_mask  <= blocked_q;
                blocked_q  <= '0;
            end else if (add_en) begin
                blocked_q <= blocked_q | (NREQ'(1) << add_id);
            end
        end
    end

endmodule

// File: rtl/tfc_tag_ctrl.sv
module tfc_tag_ctrl
    import tfc_pkg::*;
#(
    parameter int DW    = 64,
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [2:0]    req_view,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] head_data,
    output logic [IW-1:0] head_idx,
    output logic          st_wr_en,
    output logic [IW-1:0] st_wr_idx,
    output logic [DW-1:0] rdata,
    output logic          stall,
    output logic          fire,
    output logic          add_en,
    output logic [PW-1:0] fill_cnt
);

    localparam logic [3:0] DCODE = 4'($clog2(DEPTH));

    logic          e_q, f_q, t_q, e_d, f_d, t_d;
    logic [PW-1:0] ptr_q, ptr_d;
    logic [IW-1:0] rdi_q, rdi_d;
    logic [DW-1:0] tag_word;
    logic          is_sync;
    view_e         view;

    assign view     = view_e'(req_view);
    assign is_sync  = (view == VW_EF_SYNC);
    assign head_idx = rdi_q;
    assign fill_cnt = ptr_q;

    always_comb begin
        tag_word                 = '0;
        tag_word[TB_DCODE +: 4]  = DCODE;
        tag_word[TB_PTR +: PW]   = ptr_q;
        tag_word[TB_FIFO]        = 1'b1;
        tag_word[TB_TRAP]        = t_q;
        tag_word[TB_FULL]        = f_q;
        tag_word[TB_EMPTY]       = e_q;
    end

    // Operation decoder
    always_comb begin
        e_d       = e_q;
        f_d       = f_q;
        t_d       = t_q;
        ptr_d     = ptr_q;
        rdi_d     = rdi_q;
        st_wr_en  = 1'b0;
        st_wr_idx = rdi_q + ptr_q[IW-1:0];
        stall     = 1'b0;
        fire      = 1'b0;
        add_en    = 1'b0;
        rdata     = '0;
        if (req_valid) begin
            unique case (view)
                VW_BYPASS: begin
                    if (req_write) begin
                        if (ptr_q != '0) begin
                            st_wr_en  = 1'b1;
                            st_wr_idx = rdi_q + ptr_q[IW-1:0] - IW'(1);
                        end
                    end else begin
                        rdata = head_data;
                    end
                end
                VW_CTRL: begin
                    if (req_write) begin
                        t_d = req_wdata[TB_TRAP];
                        f_d = req_wdata[TB_FULL];
                        e_d = req_wdata[TB_EMPTY];
                        if (req_wdata[TB_EMPTY]) ptr_d = '0;
                    end else begin
                        rdata = tag_word;
                    end
                end
                VW_EF_SYNC, VW_EF_TRY: begin
                    if (!req_write) begin
                        f_d = 1'b0;
                        if (is_sync && e_q) begin
                            stall  = 1'b1;
                            add_en = 1'b1;
                        end else begin
                            fire = 1'b1;
                            if (ptr_q != '0) begin
                                rdata = head_data;
                                rdi_d = rdi_q + IW'(1);
                                ptr_d = ptr_q - PW'(1);
                            end
                            if (ptr_d == '0) e_d = 1'b1;
                        end
                    end else begin
                        e_d = 1'b0;
                        if (is_sync && f_q) begin
                            stall  = 1'b1;
                            add_en = 1'b1;
                        end else begin
                            fire = 1'b1;
                            if (ptr_q < PW'(DEPTH)) begin
                                st_wr_en = 1'b1;
                                ptr_d    = ptr_q + PW'(1);
                            end
                            if (ptr_d == PW'(DEPTH)) f_d = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Tag state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q   <= 1'b1;
            f_q   <= 1'b0;
            t_q   <= 1'b0;
            ptr_q <= '0;
            rdi_q <= '0;
        end else begin
            e_q   <= e_d;
            f_q   <= f_d;
            t_q   <= t_d;
            ptr_q <= ptr_d;
            rdi_q <= rdi_d;
        end
    end

endmodule

// File: rtl/tfc_cell.sv
module tfc_cell #(
    parameter int DW    = 64,
    parameter int DEPTH = 8,
    parameter int NREQ  = 8,
    localparam int IDW  = $clog2(NREQ),
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [2:0]      req_view,
    input  logic [IDW-1:0]  req_id,
    input  logic [DW-1:0]   req_wdata,
    output logic            rsp_valid,
    output logic            rsp_stall,
    output logic [DW-1:0]   rsp_rdata,
    output logic            wake_pulse,
    output logic [NREQ-1:0] wake_mask
);

    logic [IW-1:0] head_idx, st_wr_idx;
    logic [DW-1:0] head_data, op_rdata;
    logic          st_wr_en, op_stall, op_fire, op_add;
    logic [PW-1:0] fill_cnt;

    tfc_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_wr_en),
        .wr_idx  (st_wr_idx),
        .wr_data (req_wdata),
        .rd_idx  (head_idx),
        .rd_data (head_data)
    );

    tfc_tag_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_view  (req_view),
        .req_wdata (req_wdata),
        .head_data (head_data),
        .head_idx  (head_idx),
        .st_wr_en  (st_wr_en),
        .st_wr_idx (st_wr_idx),
        .rdata     (op_rdata),
        .stall     (op_stall),
        .fire      (op_fire),
        .add_en    (op_add),
        .fill_cnt  (fill_cnt)
    );

    tfc_waker #(.NREQ(NREQ)) u_waker (
        .clk        (clk),
        .rst_n      (rst_n),
        .add_en     (op_add),
        .add_id     (req_id),
        .fire       (op_fire),
        .wake_pulse (wake_pulse),
        .wake_mask  (wake_mask)
    );

    // Response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_stall <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_stall <= req_valid && op_stall;
            rsp_rdata <= req_valid ? op_rdata : '0;
        end
    end

endmodule

// File: rtl/tfc_cell_chk.sv
module tfc_cell_chk #(
    parameter int DW    = 64,
    parameter int DEPTH = 8,
    parameter int NREQ  = 8,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_write,
    input logic [2:0]      req_view,
    input logic            rsp_valid,
    input logic            rsp_stall,
    input logic [DW-1:0]   rsp_rdata,
    input logic            wake_pulse,
    input logic [NREQ-1:0] wake_mask,
    input logic [PW-1:0]   fill_cnt
);

    p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_write_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));

    p_stall_only_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_view != 3'd2)) |=> !rsp_stall);

    p_stall_no_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stall |-> !wake_pulse);

    p_wake_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    p_wake_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (wake_mask != '0));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= PW'(DEPTH));

endmodule

bind tfc_cell tfc_cell_chk #(.DW(DW), .DEPTH(DEPTH), .NREQ(NREQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_view   (req_view),
    .rsp_valid  (rsp_valid),
    .rsp_stall  (rsp_stall),
    .rsp_rdata  (rsp_rdata),
    .wake_pulse (wake_pulse),
    .wake_mask  (wake_mask),
    .fill_cnt   (fill_cnt)
);

// File: tb/tb_tfc_cell.sv
`timescale 1ns/1ps
module tb_tfc_cell;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_view = '0;
    logic [2:0]  req_id = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_stall, wake_pulse;
    logic [63:0] rsp_rdata;
    logic [7:0]  wake_mask;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tfc_cell dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_view(req_view), .req_id(req_id), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_stall(rsp_stall), .rsp_rdata(rsp_rdata),
        .wake_pulse(wake_pulse), .wake_mask(wake_mask)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  view;
        logic [2:0]  id;
        logic [31:0] wd;
        logic        stall;
        logic [31:0] rd;
        logic        wk;
        logic [7:0]  wm;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 48;
    localparam vec_t TBL [NV] = '{
        '{1'b0,3'd1,3'd0,32'h0,    1'b0,32'h3002_0001,1'b0,8'h00,4'd1},  // R1 reset tag
        '{1'b0,3'd3,3'd0,32'h0,    1'b0,32'h0,        1'b0,8'h00,4'd4},  // R4 empty try read
        '{1'b0,3'd2,3'd2,32'h0,    1'b1,32'h0,        1'b0,8'h00,4'd5},  // R5 stall read
        '{1'b1,3'd3,3'd0,32'h11,   1'b0,32'h0,        1'b1,8'h04,4'd8},  // R8 wake id2
        '{1'b0,3'd1,3'd0,32'h0,    1'b0,32'h3006_0000,1'b0,8'h00,4'd6},  // R6
        '{1'b1,3'd2,3'd1,32'h22,   1'b0,32'h0,        1'b0,8'h00,4'd6},
        '{1'b1,3'd2,3'd1,32'h33,   1'b0,32'h0,        1'b0,8'h00,4'd6},
        '{1'b0,3'd0,3'd0,32'h0,    1'b0,32'h11,       1'b0,8'h00,4'd9},  // R9 peek
        '{1'b1,3'd0,3'd0,32'hAA,   1'b0,32'h0,        1'b0,8'h00,4'd9},  // R9 overwrite newest
        '{1'b0,3'd1,3'd0,32'h0,    1'b0,32'h300E_0000,1'b0,8'h00,4'd2},  // R2
        '{1'b0,3'd3,3'd0,32'h0,    1'b0,32'h11,       1'b0,8'h00,4'd4},
        '{1'b0,3'd3,3'd0,32'h0,    1'b0,32'h22,       1'b0,8'h00,4'd4},
        '{1'b0,3'd2,3'd0,32'h0,    1'b0,32'hAA,       1'b0,8'h00,4'd4},
        '{1'b0,3'd1,3'd0,32'h0,    1'b0,32'h3002_0001,1'b0,8'h00,4'd4},
        '{1'b1,3'd3,3'd0,32'h100,  1'b0,32'h0,        1'b0,8'h00,4'd6},  // R6 fill with wrap
        '{1'b1,3'd3,3'd0,32'h101,  1'b0,32'h0,        1'b0,8'h00,4'd6},
        '{1'b1,3'd3,3'd0,32'h102,  1'b0,32'h0,        1'b0,8'h00,4'd6},
        '{1'b1,3'd3,3'd0,32'h103,  1'b0,32'h0,        1'b0,8'h00,4'd6},
        '{1'b1,3'd3,3'd0,32'h104,  1'b0,32'h0,        1'b0,8'h00,4'd6},
        '{1'b1,3'd3,3'd0,32'h105,  1'b0,32'h0,        1'b0,8'h00,4'd6},
        '{1'b1,3'd3,3'd0,32'h106,  1'b0,32'h0,        1'b0,8'h00,4'd6},
        '{1'b1,3'd3,3'd0,32'h107,  1'b0,32'h0,        1'b0,8'h00,4'd6},
        '{1'b0,3'd1,3'd0,32'h0,    1'b0,32'h3022_0002,1'b0,8'h00,4'd6},  // R6 full flag
        '{1'b1,3'd2,3'd5,32'hDEAD, 1'b1,32'h0,        1'b0,8'h00,4'd7},  // R7 stall write
        '{1'b1,3'd2,3'd7,32'hBEEF, 1'b1,32'h0,        1'b0,8'h00,4'd7},
        '{1'b1,3'd3,3'd0,32'h999,  1'b0,32'h0,        1'b1,8'hA0,4'd8},  // R8 dropped write wakes
        '{1'b0,3'd1,3'd0,32'h0,    1'b0,32'h3022_0002,1'b0,8'h00,4'd6},
        '{1'b0,3'd3,3'd0,32'h0,    1'b0,32'h100,      1'b0,8'h00,4'd4},
        '{1'b0,3'd1,3'd0,32'h0,    1'b0,32'h301E_0000,1'b0,8'h00,4'd4},
        '{1'b1,3'd1,3'd0,32'h10001,1'b0,32'h0,        1'b0,8'h00,4'd3},  // R3 T=1 E=1
        '{1'b0,3'd1,3'd0,32'h0,    1'b0,32'h3003_0001,1'b0,8'h00,4'd3},
        '{1'b1,3'd0,3'd0,32'h5555, 1'b0,32'h0,        1'b0,8'h00,4'd9},  // R9 ignored
        '{1'b0,3'd1,3'd0,32'h0,    1'b0,32'h3003_0001,1'b0,8'h00,4'd9},
        '{1'b0,3'd0,3'd0,32'h0,    1'b0,32'h101,      1'b0,8'h00,4'd9},
        '{1'b0,3'd3,3'd0,32'h0,    1'b0,32'h0,        1'b0,8'h00,4'd4},
        '{1'b0,3'd6,3'd0,32'h0,    1'b0,32'h0,        1'b0,8'h00,4'd10}, // R10 unused view
        '{1'b1,3'd5,3'd0,32'h3,    1'b0,32'h0,        1'b0,8'h00,4'd10},
        '{1'b0,3'd1,3'd0,32'h0,    1'b0,32'h3003_0001,1'b0,8'h00,4'd10},
        '{1'b1,3'd1,3'd0,32'h2,    1'b0,32'h0,        1'b0,8'h00,4'd3},  // R3 F=1 E=0
        '{1'b0,3'd1,3'd0,32'h0,    1'b0,32'h3002_0002,1'b0,8'h00,4'd3},
        '{1'b1,3'd2,3'd3,32'h42,   1'b1,32'h0,        1'b0,8'h00,4'd7},  // R7 sw full
        '{1'b0,3'd2,3'd4,32'h0,    1'b0,32'h0,        1'b1,8'h08,4'd8},
        '{1'b0,3'd1,3'd0,32'h0,    1'b0,32'h3002_0001,1'b0,8'h00,4'd4},
        '{1'b0,3'd2,3'd6,32'h0,    1'b1,32'h0,        1'b0,8'h00,4'd5},
        '{1'b0,3'd1,3'd0,32'h0,    1'b0,32'h3002_0001,1'b0,8'h00,4'd5},
        '{1'b1,3'd3,3'd0,32'h77,   1'b0,32'h0,        1'b1,8'h40,4'd8},
        '{1'b0,3'd0,3'd0,32'h0,    1'b0,32'h77,       1'b0,8'h00,4'd9},
        '{1'b0,3'd2,3'd0,32'h0,    1'b0,32'h77,       1'b0,8'h00,4'd4}
    };

    task automatic check(input string what, input int rq, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Drive at a falling edge; sample the registered response at the next one
    task automatic access(input logic wr, input logic [2:0] vw, input logic [2:0] id,
                          input logic [63:0] wd);
        req_valid = 1'b1;
        req_write = wr;
        req_view  = vw;
        req_id    = id;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_wdata = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R1: idle after reset
        check("idle rsp_valid", 1, 64'(rsp_valid), 64'd0);
        check("idle wake", 1, 64'(wake_pulse), 64'd0);

        for (int i = 0; i < NV; i++) begin
            access(TBL[i].wr, TBL[i].view, TBL[i].id, 64'(TBL[i].wd));
            check($sformatf("vec%0d valid", i), int'(TBL[i].req), 64'(rsp_valid), 64'd1);
            check($sformatf("vec%0d stall", i), int'(TBL[i].req), 64'(rsp_stall), 64'(TBL[i].stall));
            check($sformatf("vec%0d rdata", i), int'(TBL[i].req), rsp_rdata, 64'(TBL[i].rd));
            check($sformatf("vec%0d wake", i), int'(TBL[i].req), 64'(wake_pulse), 64'(TBL[i].wk));
            check($sformatf("vec%0d wmask", i), int'(TBL[i].req), 64'(wake_mask), 64'(TBL[i].wm));
        end

        // R8: wake lasts one cycle and the mask is emptied
        access(1'b0, 3'd3, 3'd0, 64'd0);          // drain remaining entry (count 0 -> returns 0)
        access(1'b0, 3'd2, 3'd1, 64'd0);          // stall id1
        check("stall id1", 5, 64'(rsp_stall), 64'd1);
        access(1'b1, 3'd3, 3'd0, 64'h5);
        check("wake id1", 8, 64'(wake_mask), 64'h02);
        @(negedge clk);
        check("wake gone next cycle", 8, 64'(wake_pulse), 64'd0);
        access(1'b1, 3'd3, 3'd0, 64'h6);
        check("no second wake", 8, 64'(wake_pulse), 64'd0);

        // R1: reset mid-run restores tag and drops blocked requesters
        access(1'b1, 3'd1, 3'd0, 64'h1);          // empty the cell
        access(1'b0, 3'd2, 3'd3, 64'd0);
        check("stall before reset", 5, 64'(rsp_stall), 64'd1);
        do_reset();
        access(1'b0, 3'd1, 3'd0, 64'd0);
        check("tag after reset", 1, rsp_rdata, 64'h3002_0001);
        access(1'b1, 3'd3, 3'd0, 64'h9);
        check("mask cleared by reset", 1, 64'(wake_pulse), 64'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog: actual=hung expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule